// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the front of a small 16-bit instruction pipeline. It holds a byte-addressed program counter and fetches one 16-bit word per cycle from a synchronous program memory with one cycle of read latency. The PC is always even and steps by two bytes per word. Some opcodes take two words. The first word of such an instruction is held back. The word that follows is then merged with it, and the two leave the block as one decoded instruction. A word whose top nibble is all ones is the second half of a pair. If it arrives without its first half, because a skip stepped over that first half or because a jump landed on it, it leaves as a no-operation.

There are two redirect sources. Absolute jumps are decoded inside the block from the paired jump encoding. The target is a word address, and the block doubles it to form the byte PC. The execute stage can also request a relative branch, with a signed offset counted in words, or a skip of the next word. Every emitted instruction is a registered bundle: the PC of its first word, an opcode class, the merged operand field and a no-operation flag.

Top module: `wordpair_fetch`

## Requirements
- R1: While `rst` is high, `imem_addr` is 0 and `out_valid` is 0. After release, the first word fetched is the one at byte address 0.
- R2: `imem_addr` bit 0 is always 0. With no redirect, the address grows by 2 every cycle and wraps modulo 2^PC_W, so byte 0x1FFFFE is followed by 0.
- R3: A word that does not open a pair and whose bits [15:12] are not 4'hF is emitted with class 0 (single), `out_opnd` = the word zero-extended, and `out_pc` = its own address.
- R4: A word with bits [15:12] = 4'hC opens a move pair. Together with the next word it is emitted once, with class 1 (move), `out_opnd` = {first[11:0], second[11:0]} and `out_pc` = the address of the first word.
- R5: A word with bits [15:8] = 8'hEF opens a jump pair. It is emitted once, with class 2 (jump) and `out_opnd` = the word address {second[11:0], first[7:0]}. Fetch then resumes at twice that word address, and the words that follow the pair in memory are never emitted.
- R6: A word with bits [15:12] = 4'hF that arrives while no pair is open is emitted with class 3, `out_nop` = 1 and `out_opnd` = 0. `out_nop` is 1 only for class 3.
- R7: While a pair is open, the next word is taken as its second word whatever its top nibble is.
- R8: A pulse on `skip_req` discards the next fetched word that reaches decode in the same cycle or later, and it closes any open pair. If that word opens a pair, its second word then comes out as a class 3 no-operation. No instruction is emitted in the cycle after the request.
- R9: A pulse on `br_req` sets the next fetch address to `out_pc` + 2 + 2·`br_off` (with `br_off` signed, in words, modulo 2^PC_W). The words in decode and in flight are dropped, no instruction is emitted in the next cycle, and an open pair and any pending skip are cancelled. Branch wins over skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Byte address presented to program memory |
| imem_rdata | input | IW | Word read from the address of the previous cycle |
| br_req | input | 1 | Relative branch request from execute |
| br_off | input | BOFF_W | Signed branch offset in words |
| skip_req | input | 1 | Skip-next-word request from execute |
| out_valid | output | 1 | Decoded instruction valid |
| out_pc | output | PC_W | Byte address of the instruction's first word |
| out_cls | output | 2 | 0 single, 1 move, 2 jump, 3 no-operation |
| out_opnd | output | 2*(IW-4) | Merged operand field |
| out_nop | output | 1 | High for a stray second word |

## Verification
The bench uses the defaults PC_W = 21, IW = 16 and BOFF_W = 11. With these, the full 20-bit jump word address maps onto the byte PC, so a jump to word 0xFFFFF reaches the top byte address, and the wrap back to 0 on the next step can be observed directly. The 11-bit offset lets negative branches cross below address 0. A 64-word program memory that repeats across the address space keeps random jump targets fetchable anywhere in the 2 MB range.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  typedef enum logic [1:0] {
    CLS_SINGLE = 2'd0,
    CLS_MOVE   = 2'd1,
    CLS_JUMP   = 2'd2,
    CLS_NOP    = 2'd3
  } op_cls_e;

  localparam logic [3:0] PFX_TAIL = 4'hF;  // second word of a pair
  localparam logic [3:0] PFX_MOVE = 4'hC;  // first word of a move pair
  localparam logic [7:0] PFX_JUMP = 8'hEF; // first word of a jump pair
endpackage

// File: rtl/wpf_pc_unit.sv
module wpf_pc_unit #(
  parameter int PC_W   = 21,
  parameter int BOFF_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_take,
  input  logic [PC_W-1:0]   br_base,
  input  logic [BOFF_W-1:0] br_off,
  input  logic              jmp_take,
  input  logic [PC_W-2:0]   jmp_word,
  output logic [PC_W-1:0]   fetch_pc,
  output logic [PC_W-1:0]   dec_pc,
  output logic              dec_live
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);
  localparam logic [PC_W-1:0] EVEN = ~PC_W'(1);

  logic [PC_W-1:0] off_bytes, br_tgt, jmp_tgt, pc_next;

  // word offset to byte offset, sign-extended when the PC is wider
  generate
    if (PC_W > BOFF_W) begin : g_sext
      assign off_bytes = {{(PC_W-BOFF_W){br_off[BOFF_W-1]}}, br_off} << 1;
    end else begin : g_trunc
      assign off_bytes = PC_W'(br_off) << 1;
    end
  endgenerate

  assign br_tgt  = (br_base + STEP + off_bytes) & EVEN;
  assign jmp_tgt = {jmp_word, 1'b0};

  always_comb begin
    if (br_take)       pc_next = br_tgt;
    else if (jmp_take) pc_next = jmp_tgt;
    else               pc_next = fetch_pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= '0;
      dec_pc   <= '0;
      dec_live <= 1'b0;
    end else begin
      fetch_pc <= pc_next;
      dec_pc   <= fetch_pc;
      dec_live <= !(br_take || jmp_take);
    end
  end
endmodule

// File: rtl/wpf_pair_decode.sv
module wpf_pair_decode
  import wpf_pkg::*;
#(
  parameter int IW   = 16,
  parameter int PC_W = 21
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  word_live,
  input  logic [IW-1:0]         word,
  input  logic [PC_W-1:0]       word_pc,
  input  logic                  skip_req,
  input  logic                  flush,
  output logic                  jmp_fire,
  output logic [PC_W-2:0]       jmp_word,
  output logic                  out_valid,
  output logic [PC_W-1:0]       out_pc,
  output op_cls_e               out_cls,
  output logic [2*(IW-4)-1:0]   out_opnd,
  output logic                  out_nop
);
  localparam int LIT_W  = IW - 4;
  localparam int OPND_W = 2 * LIT_W;
  localparam int JW     = PC_W - 1;

  logic              pend_q, skip_arm_q;
  logic [IW-1:0]     held_q;
  logic [PC_W-1:0]   held_pc_q;

  logic skip_now, take, drop, use_w;
  logic is_tail, is_move, is_jump, held_jump, opens;
  logic emit;
  op_cls_e            cls_c;
  logic [OPND_W-1:0]  opnd_c;
  logic [PC_W-1:0]    pc_c;

  assign skip_now  = skip_req || skip_arm_q;
  assign take      = word_live && !flush;
  assign drop      = take && skip_now;
  assign use_w     = take && !skip_now;

  assign is_tail   = word[IW-1 -: 4] == PFX_TAIL;
  assign is_move   = word[IW-1 -: 4] == PFX_MOVE;
  assign is_jump   = word[IW-1 -: 8] == PFX_JUMP;
  assign held_jump = held_q[IW-1 -: 8] == PFX_JUMP;
  assign opens     = is_jump || is_move;

  assign jmp_fire  = use_w && pend_q && held_jump;
  assign jmp_word  = JW'({word[LIT_W-1:0], held_q[7:0]});

  always_comb begin
    emit   = 1'b0;
    cls_c  = CLS_SINGLE;
    opnd_c = '0;
    pc_c   = word_pc;
    if (use_w) begin
      if (pend_q) begin
        emit = 1'b1;
        pc_c = held_pc_q;
        if (held_jump) begin
          cls_c  = CLS_JUMP;
          opnd_c = OPND_W'({word[LIT_W-1:0], held_q[7:0]});
        end else begin
          cls_c  = CLS_MOVE;
          opnd_c = {held_q[LIT_W-1:0], word[LIT_W-1:0]};
        end
      end else if (!opens) begin
        emit = 1'b1;
        if (is_tail) begin
          cls_c = CLS_NOP;
        end else begin
          cls_c  = CLS_SINGLE;
          opnd_c = OPND_W'(word);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      skip_arm_q <= 1'b0;
      held_q     <= '0;
      held_pc_q  <= '0;
      out_valid  <= 1'b0;
      out_pc     <= '0;
      out_cls    <= CLS_SINGLE;
      out_opnd   <= '0;
      out_nop    <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_pc   <= pc_c;
        out_cls  <= cls_c;
        out_opnd <= opnd_c;
        out_nop  <= (cls_c == CLS_NOP);
      end

      if (flush || drop || skip_req)
        pend_q <= 1'b0;
      else if (use_w)
        pend_q <= !pend_q && opens;

      if (use_w && !pend_q && opens) begin
        held_q    <= word;
        held_pc_q <= word_pc;
      end

      if (flush || drop || jmp_fire)
        skip_arm_q <= 1'b0;
      else if (skip_req)
        skip_arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wordpair_fetch.sv
module wordpair_fetch
  import wpf_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int IW     = 16,
  parameter int BOFF_W = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [PC_W-1:0]      imem_addr,
  input  logic [IW-1:0]        imem_rdata,
  input  logic                 br_req,
  input  logic [BOFF_W-1:0]    br_off,
  input  logic                 skip_req,
  output logic                 out_valid,
  output logic [PC_W-1:0]      out_pc,
  output logic [1:0]           out_cls,
  output logic [2*(IW-4)-1:0]  out_opnd,
  output logic                 out_nop
);
  logic            jmp_fire;
  logic [PC_W-2:0] jmp_word;
  logic [PC_W-1:0] dec_pc;
  logic            dec_live;
  op_cls_e         cls_q;

  wpf_pc_unit #(.PC_W(PC_W), .BOFF_W(BOFF_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .br_take  (br_req),
    .br_base  (out_pc),
    .br_off   (br_off),
    .jmp_take (jmp_fire),
    .jmp_word (jmp_word),
    .fetch_pc (imem_addr),
    .dec_pc   (dec_pc),
    .dec_live (dec_live)
  );

  wpf_pair_decode #(.IW(IW), .PC_W(PC_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .word_live (dec_live),
    .word      (imem_rdata),
    .word_pc   (dec_pc),
    .skip_req  (skip_req),
    .flush     (br_req),
    .jmp_fire  (jmp_fire),
    .jmp_word  (jmp_word),
    .out_valid (out_valid),
    .out_pc    (out_pc),
    .out_cls   (cls_q),
    .out_opnd  (out_opnd),
    .out_nop   (out_nop)
  );

  assign out_cls = cls_q;
endmodule

// File: rtl/wpf_checker.sv
module wpf_checker #(
  parameter int PC_W   = 21,
  parameter int BOFF_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   imem_addr,
  input logic              br_req,
  input logic [BOFF_W-1:0] br_off,
  input logic              skip_req,
  input logic              out_valid,
  input logic [PC_W-1:0]   out_pc,
  input logic [1:0]        out_cls,
  input logic              out_nop,
  input logic              jmp_fire
);
  logic [PC_W-1:0] br_expect;
  assign br_expect = out_pc + PC_W'(2) + (PC_W'($signed(br_off)) << 1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && !out_valid));

  a_r2_pc_even: assert property (@(posedge clk) disable iff (rst)
    imem_addr[0] == 1'b0);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!br_req && !jmp_fire) |=> imem_addr == PC_W'($past(imem_addr) + PC_W'(2)));

  a_r5_jump_emitted: assert property (@(posedge clk) disable iff (rst)
    (jmp_fire && !br_req) |=> (out_valid && out_cls == 2'd2));

  a_r6_nop_flag: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nop) |-> out_cls == 2'd3);

  a_r8_skip_drops: assert property (@(posedge clk) disable iff (rst)
    skip_req |=> !out_valid);

  a_r9_branch_target: assert property (@(posedge clk) disable iff (rst)
    br_req |=> imem_addr == $past(br_expect));

  a_r9_branch_kills: assert property (@(posedge clk) disable iff (rst)
    br_req |=> !out_valid);
endmodule

bind wordpair_fetch wpf_checker #(.PC_W(PC_W), .BOFF_W(BOFF_W)) u_chk (.*);

// File: tb/sim_wordpair_fetch.sv
module sim_wordpair_fetch;
  localparam int PERIOD = 10;
  localparam int PC_W = 21, IW = 16, BOFF_W = 11;

  logic clk = 1'b0, rst = 1'b1, br_req = 1'b0, skip_req = 1'b0;
  logic [BOFF_W-1:0] br_off = '0;
  logic [PC_W-1:0] imem_addr, out_pc;
  logic [IW-1:0] imem_rdata = '0;
  logic out_valid, out_nop;
  logic [1:0] out_cls;
  logic [23:0] out_opnd;

  logic [15:0] prog [64];
  logic [PC_W-1:0] eq_pc[$];
  logic [1:0] eq_cls[$];
  logic [23:0] eq_op[$];
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) imem_rdata <= prog[imem_addr[6:1]];

  wordpair_fetch #(.PC_W(PC_W), .IW(IW), .BOFF_W(BOFF_W)) u0 (.*);

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
    $finish;
  end

  task automatic push(input logic [PC_W-1:0] p, input logic [1:0] c, input logic [23:0] o);
    eq_pc.push_back(p); eq_cls.push_back(c); eq_op.push_back(o);
  endtask

  // expected stream for straight-line code with jumps (R2-R7)
  task automatic model_fill(input int n);
    logic [PC_W-1:0] pc = '0, hpc = '0;
    logic [15:0] held = '0, w;
    bit pend = 0;
    int got = 0;
    while (got < n) begin
      w = prog[pc[6:1]];
      if (pend) begin
        pend = 0; got++;
        if (held[15:8] == 8'hEF) begin
          push(hpc, 2'd2, {4'h0, w[11:0], held[7:0]});
          pc = {w[11:0], held[7:0], 1'b0};
        end else begin
          push(hpc, 2'd1, {held[11:0], w[11:0]});
          pc = pc + 2;
        end
      end else begin
        if (w[15:8] == 8'hEF || w[15:12] == 4'hC) begin
          pend = 1; held = w; hpc = pc;
        end else if (w[15:12] == 4'hF) begin
          push(pc, 2'd3, 24'h0); got++;
        end else begin
          push(pc, 2'd0, {8'h0, w}); got++;
        end
        pc = pc + 2;
      end
    end
  endtask

  task automatic run_expect(input string tag);
    int guard = 0;
    logic [PC_W-1:0] ep; logic [1:0] ec; logic [23:0] eo;
    while (eq_pc.size() > 0 && guard < 400) begin
      @(negedge clk);
      skip_req = 1'b0; br_req = 1'b0; guard++;
      if (out_valid) begin
        ep = eq_pc.pop_front(); ec = eq_cls.pop_front(); eo = eq_op.pop_front();
        checks++;
        if (out_pc !== ep || out_cls !== ec || out_opnd !== eo || out_nop !== (ec == 2'd3)) begin
          fails++;
          $display("FAIL %s: actual pc=%h cls=%0d op=%h nop=%b expected pc=%h cls=%0d op=%h nop=%b",
                   tag, out_pc, out_cls, out_opnd, out_nop, ep, ec, eo, ec == 2'd3);
        end
      end
    end
    if (eq_pc.size() > 0) begin
      checks++; fails++;
      $display("FAIL %s: actual %0d outputs missing expected 0", tag, eq_pc.size());
      eq_pc.delete(); eq_cls.delete(); eq_op.delete();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; skip_req = 1'b0; br_req = 1'b0;
    repeat (2) begin
      @(negedge clk);
      checks++;
      if (imem_addr !== '0 || out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1: actual addr=%h valid=%b expected addr=0 valid=0", imem_addr, out_valid);
      end
    end
    rst = 1'b0;
  endtask

  task automatic fill_plain();
    for (int i = 0; i < 64; i++) prog[i] = 16'h0100 + 16'(i);
  endtask

  function automatic logic [15:0] rnd_single();
    logic [3:0] nib = 4'($urandom % 13);
    if (nib >= 4'd12) nib = 4'hD;
    return {nib, 12'($urandom)};
  endfunction

  task automatic gen_random();
    int i = 0, k;
    while (i < 64) begin
      k = $urandom % 20;
      if (k >= 9 && k < 12 && i < 63) begin
        prog[i] = {4'hC, 12'($urandom)}; prog[i+1] = {4'hF, 12'($urandom)}; i += 2;
      end else if (k >= 12 && k < 14 && i < 63) begin
        prog[i] = {8'hEF, 8'($urandom)}; prog[i+1] = {4'hF, 12'($urandom)}; i += 2;
      end else if (k >= 14 && k < 16) begin
        prog[i] = {4'hF, 12'($urandom)}; i += 1;
      end else if (k == 16 && i < 63) begin
        prog[i] = {4'hC, 12'($urandom)}; prog[i+1] = rnd_single(); i += 2; // R7
      end else begin
        prog[i] = rnd_single(); i += 1;
      end
    end
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'h5EED_0042);
    fill_plain();

    // R1 reset state, then R3 plain stream
    do_reset();
    model_fill(6);
    run_expect("R1 R3 plain");

    // R7: open move pair consumes a non-tail word
    fill_plain(); prog[1] = 16'hC123; prog[2] = 16'h1234;
    do_reset(); model_fill(3);
    run_expect("R7 R4 pair");

    // R2 wrap: jump to word 0xFFFFF, then step past the top
    fill_plain(); prog[0] = 16'hEFFF; prog[1] = 16'hFFFF; prog[63] = 16'h0555;
    do_reset(); model_fill(5);
    run_expect("R2 R5 wrap");

    // R3 R4 R5 R6 random programs
    for (int r = 0; r < 6; r++) begin
      gen_random();
      do_reset(); model_fill(40);
      run_expect("R3 R4 R5 R6 random");
    end

    // R8 skip onto a move pair: tail becomes a no-operation
    fill_plain(); prog[1] = 16'hC123; prog[2] = 16'hF456; prog[3] = 16'h2000;
    do_reset();
    push(0, 2'd0, 24'h000100); run_expect("R8 lead");
    skip_req = 1'b1;
    push(21'h4, 2'd3, 24'h0); push(21'h6, 2'd0, 24'h002000);
    run_expect("R8 skip pair");
    skip_req = 1'b1;
    push(21'hA, 2'd0, 24'h000105);
    run_expect("R8 skip single");

    // R8 skip armed before any word is live
    fill_plain(); do_reset();
    skip_req = 1'b1;
    push(21'h2, 2'd0, 24'h000101);
    run_expect("R8 skip armed");

    // R9 branches: forward, backward, over skip, below zero
    fill_plain(); do_reset();
    push(0, 2'd0, 24'h000100); run_expect("R9 lead");
    br_req = 1'b1; br_off = 11'd5;
    push(21'hC, 2'd0, 24'h000106); run_expect("R9 forward");
    br_req = 1'b1; br_off = -11'sd4;
    push(21'h6, 2'd0, 24'h000103); run_expect("R9 backward");
    br_req = 1'b1; skip_req = 1'b1; br_off = 11'd0;
    push(21'h8, 2'd0, 24'h000104); run_expect("R9 beats skip");
    br_req = 1'b1; br_off = -11'sd10;
    push(21'h1FFFF6, 2'd0, 24'h00013B); run_expect("R9 wrap below zero");

    summary();
    $finish;
  end
endmodule